// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block is the control state machine for a memory that pairs a fast SRAM array with a shadow nonvolatile array. When it is idle, host reads and writes pass straight through to the SRAM. When it runs a transfer, it blocks all host I/O and steps the arrays through a timed two-phase operation. A STORE copies the SRAM into the shadow array: it erases the shadow first, then programs it. A RECALL copies the shadow array into the SRAM: it clears the SRAM first, then transfers the data.

Requests arrive as one-cycle strobes from three sources: a software-sequence detector (store or recall), a store pin, and a supply-good comparator. A second comparator bit reports whether the backup capacitor is charged. A write-done strobe feeds a dirty flag, which records whether any SRAM write has completed since the last STORE. Pin-requested stores and stores on supply failure are skipped when the array is clean. Software stores run whether or not the array is dirty.

After reset a RECALL is already pending, and every supply failure latches another. A pending RECALL starts as soon as the supply is good and the sequencer is idle, so the recall period counts from the moment the supply crosses back above the threshold. Every phase length is a parameter in clock cycles.

Top module: `nv_xfer_seq`

## Requirements
- R1: A STORE drives erase_o for exactly ERASE_CYC cycles, then program_o for exactly PROG_CYC cycles, then returns to idle. At most one phase output is high in any cycle.
- R2: A RECALL drives clear_o for exactly CLEAR_CYC cycles, then transfer_o for exactly XFER_CYC cycles, then returns to idle.
- R3: busy_o is high exactly while a phase output is high. io_inhibit_o is high whenever busy_o is high, and also whenever supply_ok_i is low.
- R4: Once a STORE or RECALL has started, it runs to completion. Any request or write strobe that arrives while busy_o is high has no effect, either on the running operation or on anything that follows it.
- R5: The dirty flag is cleared by reset. It is set by a wr_done_i strobe while not busy. It is cleared when a STORE completes. A RECALL does not clear it.
- R6: A pin_store_i request starts a STORE only if the dirty flag is set. A sw_store_i request starts a STORE regardless of the dirty flag.
- R7: While cap_ok_i is low, sw_store_i and pin_store_i requests start nothing.
- R8: When supply_ok_i falls from 1 to 0 (edge taken against its value at the previous clock), a STORE starts if the dirty flag is set. In every case a RECALL becomes pending.
- R9: A pending RECALL (pending from reset, or latched by a supply failure) starts in the first cycle in which the sequencer is idle and supply_ok_i is high. No request of any kind is accepted while supply_ok_i is low.
- R10: If a STORE and a RECALL are requested in the same clock, only the STORE runs.
- R11: After reset busy_o and all phase outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_store_i | input | 1 | Store strobe from the software-sequence detector |
| sw_recall_i | input | 1 | Recall strobe from the software-sequence detector |
| pin_store_i | input | 1 | Store request from the store pin |
| supply_ok_i | input | 1 | Supply is above the switch threshold |
| cap_ok_i | input | 1 | Backup capacitor is above the switch threshold |
| wr_done_i | input | 1 | An SRAM write has completed |
| erase_o | output | 1 | Shadow erase phase |
| program_o | output | 1 | Shadow program phase |
| clear_o | output | 1 | SRAM clear phase |
| transfer_o | output | 1 | Shadow-to-SRAM transfer phase |
| busy_o | output | 1 | A nonvolatile operation is running |
| io_inhibit_o | output | 1 | Host reads, writes and outputs are blocked |

## Verification
The assertions check on every cycle the properties that hold locally:
- phase outputs are mutually exclusive;
- erase always hands over to program, and clear to transfer;
- inhibit covers busy, and a running operation never stops early;
- a write while idle sets the dirty flag;
- a pin store never starts on a clean array, and no store starts with a low capacitor while the supply is good;
- store and recall never start together.

The exact phase lengths, the skipped stores, the ignored requests during a transfer, and the dirty flag surviving a recall cannot be seen in any single cycle. The bench's scenarios show them, by comparing whole sequences of phase runs against a queue of expected runs.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ERASE = 3'd1,
    ST_PROG  = 3'd2,
    ST_CLEAR = 3'd3,
    ST_XFER  = 3'd4
  } seq_state_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/nv_phase_timer.sv
module nv_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R1, R2: a load sets the phase length exactly
  a_r1_timer_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/nv_dirty_tracker.sv
module nv_dirty_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic busy_i,
  input  logic store_done_i,
  output logic dirty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                dirty_o <= 1'b0;
    else if (store_done_i)      dirty_o <= 1'b0;
    else if (wr_i && !busy_i)   dirty_o <= 1'b1;
  end

  a_r5_write_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_i) |=> dirty_o);
  a_r5_store_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_done_i |=> !dirty_o);
endmodule

// File: rtl/nv_req_arbiter.sv
module nv_req_arbiter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic sw_store_i,
  input  logic sw_recall_i,
  input  logic pin_store_i,
  input  logic supply_ok_i,
  input  logic supply_fall_i,
  input  logic cap_ok_i,
  input  logic dirty_i,
  input  logic recall_pend_i,
  output logic start_store_o,
  output logic start_recall_o
);
  logic host_store, fail_store;

  assign host_store = supply_ok_i && cap_ok_i && (sw_store_i || (pin_store_i && dirty_i));
  assign fail_store = supply_fall_i && dirty_i;

  assign start_store_o  = idle_i && (host_store || fail_store);
  assign start_recall_o = idle_i && !start_store_o && supply_ok_i &&
                          (sw_recall_i || recall_pend_i);

  a_r6_pin_needs_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_store_o && !sw_store_i && !supply_fall_i) |-> dirty_i);
  a_r7_cap_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_store_o && supply_ok_i) |-> cap_ok_i);
  a_r10_store_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_store_o |-> !start_recall_o);
endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq
  import nv_seq_pkg::*;
#(
  parameter int ERASE_CYC = 800_000,
  parameter int PROG_CYC  = 1_000_000,
  parameter int CLEAR_CYC = 400,
  parameter int XFER_CYC  = 3_600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_store_i,
  input  logic sw_recall_i,
  input  logic pin_store_i,
  input  logic supply_ok_i,
  input  logic cap_ok_i,
  input  logic wr_done_i,
  output logic erase_o,
  output logic program_o,
  output logic clear_o,
  output logic transfer_o,
  output logic busy_o,
  output logic io_inhibit_o
);
  localparam int MAX_LEN = max4(ERASE_CYC, PROG_CYC, CLEAR_CYC, XFER_CYC);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] CLEAR_LD = CNT_W'(CLEAR_CYC - 1);
  localparam logic [CNT_W-1:0] XFER_LD  = CNT_W'(XFER_CYC - 1);

  seq_state_t       state_q, state_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             tmr_zero;
  logic             supply_q, recall_pend_q, supply_fall;
  logic             dirty, start_store, start_recall, store_done, idle;

  assign idle        = (state_q == ST_IDLE);
  assign supply_fall = supply_q && !supply_ok_i;
  assign store_done  = (state_q == ST_PROG) && tmr_zero;

  nv_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (tmr_zero)
  );

  nv_dirty_tracker u_dirty (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_done_i),
    .busy_i       (!idle),
    .store_done_i (store_done),
    .dirty_o      (dirty)
  );

  nv_req_arbiter u_arb (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .idle_i         (idle),
    .sw_store_i     (sw_store_i),
    .sw_recall_i    (sw_recall_i),
    .pin_store_i    (pin_store_i),
    .supply_ok_i    (supply_ok_i),
    .supply_fall_i  (supply_fall),
    .cap_ok_i       (cap_ok_i),
    .dirty_i        (dirty),
    .recall_pend_i  (recall_pend_q),
    .start_store_o  (start_store),
    .start_recall_o (start_recall)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_store) begin
          state_d = ST_ERASE; load = 1'b1; load_val = ERASE_LD;
        end else if (start_recall) begin
          state_d = ST_CLEAR; load = 1'b1; load_val = CLEAR_LD;
        end
      end
      ST_ERASE: if (tmr_zero) begin
        state_d = ST_PROG; load = 1'b1; load_val = PROG_LD;
      end
      ST_PROG:  if (tmr_zero) state_d = ST_IDLE;
      ST_CLEAR: if (tmr_zero) begin
        state_d = ST_XFER; load = 1'b1; load_val = XFER_LD;
      end
      ST_XFER:  if (tmr_zero) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      supply_q      <= 1'b0;
      recall_pend_q <= 1'b1;   // power-up recall
    end else begin
      state_q  <= state_d;
      supply_q <= supply_ok_i;
      if (supply_fall)       recall_pend_q <= 1'b1;
      else if (start_recall) recall_pend_q <= 1'b0;
    end
  end

  assign erase_o      = (state_q == ST_ERASE);
  assign program_o    = (state_q == ST_PROG);
  assign clear_o      = (state_q == ST_CLEAR);
  assign transfer_o   = (state_q == ST_XFER);
  assign busy_o       = !idle;
  assign io_inhibit_o = busy_o || !supply_ok_i;

  a_r1_onehot_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({erase_o, program_o, clear_o, transfer_o}));
  a_r1_erase_to_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_o && tmr_zero) |=> program_o);
  a_r2_clear_to_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_o && tmr_zero) |=> transfer_o);
  a_r3_inhibit_covers_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> io_inhibit_o);
  a_r4_runs_to_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tmr_zero) |=> (busy_o && $stable({erase_o, program_o, clear_o, transfer_o})));
endmodule

// File: tb/tb_nv_xfer_seq.sv
module tb_nv_xfer_seq;
  localparam int E_C = 4, P_C = 6, C_C = 3, X_C = 5;
  localparam int K_ERASE = 1, K_PROG = 2, K_CLEAR = 3, K_XFER = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sw_store = 0, sw_recall = 0, pin_store = 0, supply_ok = 0, cap_ok = 1, wr_done = 0;
  logic erase, prog, clr, xfer, busy, inhibit;

  int vectors = 0, miscompares = 0;
  int    exp_kind[$];
  int    exp_len[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;

  nv_xfer_seq #(.ERASE_CYC(E_C), .PROG_CYC(P_C), .CLEAR_CYC(C_C), .XFER_CYC(X_C)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sw_store_i(sw_store), .sw_recall_i(sw_recall),
    .pin_store_i(pin_store), .supply_ok_i(supply_ok), .cap_ok_i(cap_ok), .wr_done_i(wr_done),
    .erase_o(erase), .program_o(prog), .clear_o(clr), .transfer_o(xfer),
    .busy_o(busy), .io_inhibit_o(inhibit));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int kind, input int len, input string tag);
    exp_kind.push_back(kind); exp_len.push_back(len); exp_tag.push_back(tag);
  endtask

  task automatic expect_store(input string tag);
    push(K_ERASE, E_C, {tag, " R1 erase"}); push(K_PROG, P_C, {tag, " R1 program"});
  endtask

  task automatic expect_recall(input string tag);
    push(K_CLEAR, C_C, {tag, " R2 clear"}); push(K_XFER, X_C, {tag, " R2 transfer"});
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
    check(exp_kind.size() == 0, "expected runs still queued", exp_kind.size(), 0);
  endtask

  task automatic quiet(input string tag);
    bit seen = 0;
    repeat (15) begin
      @(negedge clk);
      if (busy) seen = 1;
    end
    check(!seen, tag, seen, 0);
  endtask

  // monitor: collect phase runs and compare against the queue
  int run_kind = 0, run_len = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      int k;
      k = erase ? K_ERASE : prog ? K_PROG : clr ? K_CLEAR : xfer ? K_XFER : 0;
      if ($countones({erase, prog, clr, xfer}) > 1)
        check(0, "R1 phases not exclusive", $countones({erase, prog, clr, xfer}), 1);
      if ((k != 0) != busy) check(0, "R3 busy vs phase", busy, k != 0);
      if (busy && !inhibit) check(0, "R3 inhibit during busy", inhibit, 1);
      if (k != run_kind) begin
        if (run_kind != 0) begin
          if (exp_kind.size() == 0) begin
            check(0, "R4 unexpected phase run", run_kind, 0);
          end else begin
            int ek, el; string et;
            ek = exp_kind.pop_front(); el = exp_len.pop_front(); et = exp_tag.pop_front();
            check(ek == run_kind, {et, " kind"}, run_kind, ek);
            check(el == run_len, {et, " length"}, run_len, el);
          end
        end
        run_kind = k; run_len = 1;
      end else begin
        run_len++;
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !erase && !prog && !clr && !xfer, "R11 reset idle", busy, 0);
    check(inhibit, "R3 inhibit while supply low", inhibit, 1);
    rst_ni = 1'b1;
    // R9: no recall while supply low, then power-up recall
    quiet("R9 no recall while supply low");
    expect_recall("R9 power-up");
    @(negedge clk); supply_ok = 1'b1;
    settle();
    check(!inhibit, "R3 inhibit released", inhibit, 0);

    // R6: clean pin store skipped, software store runs
    pulse(pin_store);
    quiet("R6 clean pin store skipped");
    expect_store("R6 sw store on clean array");
    pulse(sw_store);
    check(busy && inhibit, "R3 busy+inhibit mid store", busy, 1);
    settle();

    // R5/R6: write then pin store runs; afterwards clean again
    pulse(wr_done);
    expect_store("R6 dirty pin store");
    pulse(pin_store);
    settle();
    pulse(pin_store);
    quiet("R5 dirty cleared by store");

    // R7: capacitor low inhibits sw and pin stores
    pulse(wr_done);
    cap_ok = 1'b0;
    pulse(sw_store);
    quiet("R7 sw store with cap low");
    pulse(pin_store);
    quiet("R7 pin store with cap low");
    cap_ok = 1'b1;

    // R5: recall keeps dirty flag (still dirty from write above)
    expect_recall("R5 sw recall");
    pulse(sw_recall);
    settle();
    expect_store("R5 dirty survives recall");
    pulse(pin_store);
    settle();

    // R10: simultaneous store and recall
    expect_store("R10 store wins");
    @(negedge clk); sw_store = 1; sw_recall = 1;
    @(negedge clk); sw_store = 0; sw_recall = 0;
    settle();

    // R4: requests and writes during a busy store ignored
    expect_store("R4 base store");
    pulse(sw_store);
    sw_recall = 1; pin_store = 1; wr_done = 1; sw_store = 1;
    @(negedge clk); sw_recall = 0; pin_store = 0; wr_done = 0; sw_store = 0;
    settle();
    pulse(pin_store);
    quiet("R4 write during busy ignored");

    // R8: supply failure, dirty -> store, then recall on return
    pulse(wr_done);
    expect_store("R8 power-fail store");
    @(negedge clk); supply_ok = 1'b0;
    settle();
    check(inhibit && !busy, "R3 inhibit while supply down", inhibit, 1);
    pulse(sw_store);
    quiet("R9 request ignored while supply down");
    expect_recall("R9 recall on supply return");
    @(negedge clk); supply_ok = 1'b1;
    settle();

    // R8: supply failure on clean array -> no store, still recall
    @(negedge clk); supply_ok = 1'b0;
    quiet("R8 clean power-fail skipped");
    expect_recall("R8 recall latched when clean");
    @(negedge clk); supply_ok = 1'b1;
    settle();

    summary();
  end
endmodule